// File: doc/BRIEF.md
# External Frame Sync Generator Gate

This block keeps a free-running video timing generator in step with an outside frame trigger. It does so by handing the generator its clock-enable one frame at a time. A rising edge on the asynchronous trigger input starts a frame. The generator's own end-of-frame pulse, which fires at the last position of the frame, withdraws the enable. The generator therefore always stops on a frame boundary and never runs into a new frame on its own. Because it does not run on, the next outside trigger always finds it parked at the start of a frame and can realign it.

The trigger input is brought into the video clock domain through a synchroniser. A rising-edge detector then reduces it to a single-cycle pulse. The end-of-frame input is also edge detected, so a level held for several cycles counts as one event. A trigger that arrives while a frame is still running is dropped rather than queued, and it raises a sticky overrun flag. Every pin is a plain control or status signal. No data flows through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `frame_lock_gate`

## Requirements
- R1: After reset, `gen_clken_o` is low and `overrun_o` is low. The block waits for a trigger.
- R2: A rising edge on `ext_sync_i` makes `gen_clken_o` rise at the third rising clock edge after the input changes, with the default two synchroniser stages. An input held high produces one enable event only.
- R3: While `gen_clken_o` is high, it stays high until a rising edge of `gen_fsync_i` is seen. It falls at the first clock edge at which that rising level is present.
- R4: With a generator that advances only while enabled and raises `gen_fsync_i` at its last frame position, each trigger yields exactly frame-length cycles of enable. This holds for frame lengths 2 to 9.
- R5: A trigger edge that arrives while `gen_clken_o` is high neither extends nor restarts the frame. It sets `overrun_o`.
- R6: `overrun_o` stays high once set, until reset.
- R7: A `gen_fsync_i` level held high for several cycles produces only one disable. A level still high when a new frame starts does not end that frame.
- R8: A rising edge of `gen_fsync_i` while `gen_clken_o` is low has no effect. The next trigger still starts a full frame.
- R9: The trigger/enable/disable cycle repeats without limit. Each new trigger after a completed frame starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sync_i | input | 1 | External frame trigger, asynchronous to clk |
| gen_fsync_i | input | 1 | End-of-frame pulse from the timing generator |
| gen_clken_o | output | 1 | Clock-enable to the timing generator |
| overrun_o | output | 1 | Sticky flag: a trigger was dropped during a running frame |

## Verification
A wrong gate state shows at `gen_clken_o` on the next clock edge. An enable that is left high makes the modelled generator run into a second frame, which shows up as a high count longer than the frame length. An enable that drops early shows up as a shorter count. A broken synchroniser or edge detector shifts the rising edge of the enable away from the third edge after the trigger, or makes a held trigger start more than one frame. A trigger taken during a running frame shows either as a frame stretched past its length or as `overrun_o` missing one edge after the dropped pulse.

// File: rtl/frame_lock_pkg.sv
package frame_lock_pkg;
  typedef enum logic {
    GATE_IDLE = 1'b0,
    GATE_RUN  = 1'b1
  } gate_state_t;
endpackage

// File: rtl/fl_sync.sv
// Multi-stage synchroniser for a single asynchronous level.
module fl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= 1'b0;
        else        q_r <= d_i;
      end
      assign q_o = q_r;
    end else begin : g_chain
      logic [STAGES-1:0] chain_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_r <= '0;
        else        chain_r <= {chain_r[STAGES-2:0], d_i};
      end
      assign q_o = chain_r[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/fl_edge.sv
// Rising-edge detector: one-cycle pulse per low-to-high transition.
module fl_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_r;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_r <= 1'b0;
    else        prev_r <= lvl_i;
  end
  assign rise_o = lvl_i & ~prev_r;
endmodule

// File: rtl/fl_gate_fsm.sv
// Enable gate: trigger opens one frame, end-of-frame closes it.
module fl_gate_fsm
  import frame_lock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic frame_end_i,
  output logic clken_o,
  output logic overrun_o
);
  gate_state_t state_r, state_n;
  logic        ovr_r;

  always_comb begin
    state_n = state_r;
    unique case (state_r)
      GATE_IDLE: if (trig_i)      state_n = GATE_RUN;
      GATE_RUN:  if (frame_end_i) state_n = GATE_IDLE;
      default:                    state_n = GATE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_r <= GATE_IDLE;
      ovr_r   <= 1'b0;
    end else begin
      state_r <= state_n;
      if (state_r == GATE_RUN && trig_i) ovr_r <= 1'b1;
    end
  end

  assign clken_o   = (state_r == GATE_RUN);
  assign overrun_o = ovr_r;
endmodule

// File: rtl/frame_lock_gate.sv
// Top: synchronise trigger, detect edges, gate the generator enable.
module frame_lock_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_sync_i,
  input  logic gen_fsync_i,
  output logic gen_clken_o,
  output logic overrun_o
);
  logic ext_sync_q;
  logic trig_pulse;
  logic fs_rise;

  fl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (ext_sync_i),
    .q_o   (ext_sync_q)
  );

  fl_edge u_trig_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (ext_sync_q),
    .rise_o (trig_pulse)
  );

  fl_edge u_fs_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (gen_fsync_i),
    .rise_o (fs_rise)
  );

  fl_gate_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_i      (trig_pulse),
    .frame_end_i (fs_rise),
    .clken_o     (gen_clken_o),
    .overrun_o   (overrun_o)
  );
endmodule

// File: rtl/frame_lock_gate_chk.sv
module frame_lock_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic trig,
  input logic fs_edge,
  input logic clken,
  input logic overrun
);
  AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) trig |=> !trig); // R2
  AST_TRIG_OPENS: assert property (@(posedge clk) disable iff (!rst_n) (!clken && trig) |=> clken); // R2
  AST_RISE_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n) (!clken && !trig) |=> !clken); // R8
  AST_HOLD_OPEN: assert property (@(posedge clk) disable iff (!rst_n) (clken && !fs_edge) |=> clken); // R3
  AST_FRAME_CLOSES: assert property (@(posedge clk) disable iff (!rst_n) (clken && fs_edge) |=> !clken); // R3
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n) (clken && trig) |=> overrun); // R5
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overrun |=> overrun); // R6
endmodule

bind frame_lock_gate frame_lock_gate_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .trig    (trig_pulse),
  .fs_edge (fs_rise),
  .clken   (gen_clken_o),
  .overrun (overrun_o)
);

// File: tb/frame_lock_gate_tb_top.sv
`timescale 1ns/1ps
module frame_lock_gate_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_sync = 1'b0;
  logic man_fs = 1'b0;
  logic use_model = 1'b0;
  logic clken, overrun;
  logic gen_fs;
  int   frame_len = 4;
  int   mdl_cnt;
  int   vectors = 0;
  int   errors = 0;
  int   cycles = 0;
  bit   done = 0;

  always #4 clk = ~clk; // 125 MHz

  // Generator model: advances only while enabled, flags its last position.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdl_cnt <= 0;
    else if (clken) mdl_cnt <= (mdl_cnt == frame_len - 1) ? 0 : mdl_cnt + 1;
  end
  assign gen_fs = use_model ? (mdl_cnt == frame_len - 1) : man_fs;

  frame_lock_gate dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_sync_i  (ext_sync),
    .gen_fsync_i (gen_fs),
    .gen_clken_o (clken),
    .overrun_o   (overrun)
  );

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
      report();
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%0b exp=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ext_sync = 1'b0; man_fs = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  // Raise trigger and check the enable appears on the third edge (R2).
  task automatic trigger_and_check_rise(string req);
    ext_sync = 1'b1;
    step(2);
    chk(req, clken, 1'b0);
    step(1);
    chk(req, clken, 1'b1);
  endtask

  initial begin
    do_reset();
    chk("R1", clken, 1'b0);
    chk("R1", overrun, 1'b0);

    // R2 latency and held level: one event only
    trigger_and_check_rise("R2");
    step(6);
    chk("R3", clken, 1'b1); // no frame end seen yet
    man_fs = 1'b1;
    step(1);
    chk("R3", clken, 1'b0);
    step(5);
    chk("R2", clken, 1'b0); // trigger still held high: no second frame
    chk("R7", clken, 1'b0); // fsync held high: nothing new
    ext_sync = 1'b0;

    // R7: new frame with fsync still held high is not ended
    step(4);
    trigger_and_check_rise("R7");
    step(5);
    chk("R7", clken, 1'b1);
    man_fs = 1'b0;
    step(2);
    chk("R7", clken, 1'b1);
    man_fs = 1'b1;
    step(1);
    chk("R3", clken, 1'b0);
    man_fs = 1'b0;
    ext_sync = 1'b0;
    chk("R5", overrun, 1'b0);

    // R8: frame end while idle has no effect
    step(3);
    man_fs = 1'b1; step(1); man_fs = 1'b0; step(3);
    chk("R8", clken, 1'b0);
    trigger_and_check_rise("R8");
    ext_sync = 1'b0;

    // R5: trigger during a running frame is dropped, overrun set
    step(4);
    ext_sync = 1'b1;
    step(3);
    chk("R5", clken, 1'b1);
    chk("R5", overrun, 1'b1);
    ext_sync = 1'b0;
    step(4);
    man_fs = 1'b1; step(1); man_fs = 1'b0;
    chk("R5", clken, 1'b0);
    step(6);
    chk("R5", clken, 1'b0); // not queued
    chk("R6", overrun, 1'b1);

    // Sweep with generator model: frame lengths and gaps (R4, R9)
    do_reset();
    chk("R1", overrun, 1'b0);
    use_model = 1'b1;
    for (int len = 2; len <= 9; len++) begin
      for (int gap = 0; gap < 4; gap++) begin
        int hi;
        frame_len = len;
        trigger_and_check_rise("R9");
        ext_sync = 1'b0;
        hi = 1;
        for (int k = 0; k < 40; k++) begin
          step(1);
          if (clken) hi++;
          else break;
        end
        vectors++;
        if (hi != len) begin
          errors++;
          $display("FAIL R4: act=%0d exp=%0d enable cycles", hi, len);
        end
        step(gap + 1);
        chk("R4", clken, 1'b0);
        chk("R6", overrun, 1'b0);
      end
    end
    report();
  end
endmodule